// File: doc/BRIEF.md
# Per-Nibble Edge Search Tracker

This block follows a delay or phase sweep and finds, separately for every 4-bit group of a wide sampled data word, the sweep step at which that group makes its first clean level change in the chosen direction. An outside sequencer steps the delay setting. For each setting it presents one sampled word, the index of the step and a valid strobe. The block runs one small state machine per group. Each machine first records a baseline level. It then watches for the edge, and once the edge is found it holds the step index until the next sweep.

A mode input chooses the direction. In falling mode a group has to be seen fully high before a fully low sample counts as the edge. In rising mode the same holds the other way round. A group whose bits are mixed never counts as either level once a baseline has been recorded. The mode is captured when a sweep is started, so that a new mode cannot take effect halfway through a sweep. A per-group done flag, a per-group found step and a global all-done flag make up the whole result interface.

Top module: `edge_sweep_tracker`

## Requirements
- R1: After reset, and in the cycle after `start_i` or `clear_i` is high, every `done_o` bit is 0, every `delay_o` field is 0, `all_done_o` is 0, and every tracker waits for a baseline sample.
- R2: Group n reads bits [4n+3:4n] of `smp_word_i` and reports on `done_o[n]` and on `delay_o[8n+7:8n]`. Bits 0..63 form groups 0..15 and bits 64..71 form groups 16..17.
- R3: The first accepted sample after a start or clear sets the baseline. The baseline is high if all four bits are 1 and low otherwise, mixed values included. This sample never sets `done_o`.
- R4: In falling mode (latched mode 0), a high tracker whose group reads 0000 sets its done flag and captures `step_i` in that cycle.
- R5: In falling mode, a low tracker goes high only on 1111. A low-to-high crossing never sets done.
- R6: In rising mode (latched mode 1), a low tracker whose group reads 1111 sets its done flag and captures `step_i`.
- R7: In rising mode, a high tracker goes low on 0000 without setting done, so that a later 1111 completes it.
- R8: Once a baseline exists, a mixed group value (neither 1111 nor 0000) leaves the tracker unchanged.
- R9: A tracker that is done keeps its flag and its captured step until the next start or clear.
- R10: A tracker changes only in cycles where `smp_valid_i` is high. `start_i` and `clear_i` take priority over a sample in the same cycle, and that sample is dropped.
- R11: `all_done_o` is high exactly when all 18 done flags are high.
- R12: The mode is taken from `rise_mode_i` only in a cycle with `start_i` high. `clear_i` keeps the latched mode, and changes of `rise_mode_i` at any other time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sweep: clear trackers and latch mode |
| clear_i | input | 1 | Clear trackers, keep latched mode |
| rise_mode_i | input | 1 | 1 = rising-edge search, 0 = falling-edge search |
| smp_valid_i | input | 1 | Sample word and step index are valid |
| smp_word_i | input | 72 | Sampled data word |
| step_i | input | 8 | Sweep step index of this sample |
| done_o | output | 18 | Per-group edge-found flags |
| delay_o | output | 144 | Per-group captured step, 8 bits per group |
| all_done_o | output | 1 | All groups have found their edge |

## Verification
The hardest case to reach is the two-crossing path. In it a tracker has to cross away from its baseline without finishing: low to high in falling mode, or high to low in rising mode. Only after that does the completing edge come. The path must also be reached while mixed group values are present. The directed stimulus builds this path step by step, with one set of groups starting high and the other starting low. It places mixed-value and strobe-low cycles between the crossings. Long random sweeps then mix 0000, 1111 and mixed groups per group, change the mode input in the middle of sweeps and insert clears. A behavioural model is compared against the outputs on every clock.

// File: rtl/est_pkg.sv
package est_pkg;
   typedef enum logic [1:0] {
      TRK_WAIT = 2'd0,
      TRK_HI   = 2'd1,
      TRK_LO   = 2'd2,
      TRK_HIT  = 2'd3
   } trk_state_e;
endpackage

// File: rtl/nibble_tracker.sv
module nibble_tracker #(
   parameter int GRP_W  = 4,
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              adv,
   input  logic              rise_mode,
   input  logic [GRP_W-1:0]  grp,
   input  logic [STEP_W-1:0] step,
   output logic              hit,
   output logic [STEP_W-1:0] delay
);
   import est_pkg::*;

   trk_state_e state_q, state_d;
   logic [STEP_W-1:0] delay_q;
   logic all_hi, all_lo, capture;

   assign all_hi = &grp;
   assign all_lo = ~|grp;

   always_comb begin
      state_d = state_q;
      capture = 1'b0;
      if (adv) begin
         unique case (state_q)
            TRK_WAIT: state_d = all_hi ? TRK_HI : TRK_LO;
            TRK_HI: if (all_lo) begin
               if (rise_mode) state_d = TRK_LO;
               else begin
                  state_d = TRK_HIT;
                  capture = 1'b1;
               end
            end
            TRK_LO: if (all_hi) begin
               if (rise_mode) begin
                  state_d = TRK_HIT;
                  capture = 1'b1;
               end else state_d = TRK_HI;
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TRK_WAIT;
         delay_q <= '0;
      end else if (flush) begin
         state_q <= TRK_WAIT;
         delay_q <= '0;
      end else begin
         state_q <= state_d;
         if (capture) delay_q <= step;
      end
   end

   assign hit   = (state_q == TRK_HIT);
   assign delay = delay_q;
endmodule

// File: rtl/done_reduce.sv
module done_reduce #(
   parameter int N = 18
) (
   input  logic [N-1:0] flags,
   output logic         all
);
   localparam int HALF = N / 2;
   generate
      if (N == 1) begin : g_leaf
         assign all = flags[0];
      end else begin : g_split
         logic lo_all, hi_all;
         done_reduce #(.N(HALF))     u_lo (.flags(flags[HALF-1:0]), .all(lo_all));
         done_reduce #(.N(N - HALF)) u_hi (.flags(flags[N-1:HALF]), .all(hi_all));
         assign all = lo_all & hi_all;
      end
   endgenerate
endmodule

// File: rtl/edge_sweep_tracker.sv
module edge_sweep_tracker #(
   parameter int GROUPS = 18,
   parameter int GRP_W  = 4,
   parameter int STEP_W = 8,
   localparam int WORD_W = GROUPS * GRP_W,
   localparam int DLY_W  = GROUPS * STEP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              clear_i,
   input  logic              rise_mode_i,
   input  logic              smp_valid_i,
   input  logic [WORD_W-1:0] smp_word_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [GROUPS-1:0] done_o,
   output logic [DLY_W-1:0]  delay_o,
   output logic              all_done_o
);
   generate
      if (GROUPS < 1) begin : g_bad_groups
         $error("GROUPS must be at least 1");
      end
      if (GRP_W < 1) begin : g_bad_grp
         $error("GRP_W must be at least 1");
      end
      if (STEP_W < 1) begin : g_bad_step
         $error("STEP_W must be at least 1");
      end
   endgenerate

   logic mode_q;
   logic flush, adv;

   assign flush = start_i | clear_i;
   assign adv   = smp_valid_i & ~flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= 1'b0;
      else if (start_i) mode_q <= rise_mode_i;
   end

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_trk
         nibble_tracker #(.GRP_W(GRP_W), .STEP_W(STEP_W)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .adv      (adv),
            .rise_mode(mode_q),
            .grp      (smp_word_i[g*GRP_W +: GRP_W]),
            .step     (step_i),
            .hit      (done_o[g]),
            .delay    (delay_o[g*STEP_W +: STEP_W])
         );
      end
   endgenerate

   done_reduce #(.N(GROUPS)) u_all (.flags(done_o), .all(all_done_o));
endmodule

// File: rtl/est_checks.sv
module est_checks #(
   parameter int GROUPS = 18,
   parameter int GRP_W  = 4,
   parameter int STEP_W = 8,
   localparam int WORD_W = GROUPS * GRP_W,
   localparam int DLY_W  = GROUPS * STEP_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              clear_i,
   input logic              rise_mode_i,
   input logic              smp_valid_i,
   input logic [WORD_W-1:0] smp_word_i,
   input logic [STEP_W-1:0] step_i,
   input logic [GROUPS-1:0] done_o,
   input logic [DLY_W-1:0]  delay_o,
   input logic              all_done_o
);
   // R1: start or clear empties every tracker
   a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || clear_i) |=> (done_o == '0 && delay_o == '0));

   // R9: done flags stay set without start or clear
   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !clear_i) |=> ((done_o & $past(done_o)) == $past(done_o)));

   // R10: no strobe, no change
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid_i && !start_i && !clear_i) |=> ($stable(done_o) && $stable(delay_o)));

   // R11: global flag follows the per-group flags
   a_r11_all_done: assert property (@(posedge clk) disable iff (!rst_n)
      all_done_o == (done_o == {GROUPS{1'b1}}));

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         // R4, R6: a new done flag comes with the step of that sample
         a_r4_capture_step: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done_o[g]) |-> ($past(smp_valid_i) &&
                                  delay_o[g*STEP_W +: STEP_W] == $past(step_i)));
         // R1: delay reads zero until done
         a_r1_delay_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !done_o[g] |-> (delay_o[g*STEP_W +: STEP_W] == '0));
      end
   endgenerate
endmodule

bind edge_sweep_tracker est_checks #(.GROUPS(GROUPS), .GRP_W(GRP_W), .STEP_W(STEP_W)) u_chk (.*);

// File: tb/edge_sweep_tracker_test.sv
module edge_sweep_tracker_test;
   localparam int NG = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, clear_i = 1'b0, rise_mode_i = 1'b0, smp_valid_i = 1'b0;
   logic [71:0] smp_word_i = '0;
   logic [7:0]  step_i = '0;
   logic [NG-1:0] done_o;
   logic [NG*8-1:0] delay_o;
   logic all_done_o;

   int errors = 0;
   int checks = 0;
   string tag = "R1";

   int  mst [NG];
   int  mdl [NG];
   bit  mmode = 1'b0;

   always #4 clk = ~clk;

   edge_sweep_tracker uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
      .rise_mode_i(rise_mode_i), .smp_valid_i(smp_valid_i),
      .smp_word_i(smp_word_i), .step_i(step_i),
      .done_o(done_o), .delay_o(delay_o), .all_done_o(all_done_o)
   );

   task automatic check(input string t, input logic [191:0] act, input logic [191:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int n = 0; n < NG; n++) begin mst[n] = 0; mdl[n] = 0; end
   endtask

   // states: 0 waiting, 1 high, 2 low, 3 done
   task automatic model_step(input bit st, input bit cl, input bit v, input bit rm,
                             input logic [71:0] w, input logic [7:0] s);
      if (st || cl) begin
         model_reset();
         if (st) mmode = rm;
      end else if (v) begin
         for (int n = 0; n < NG; n++) begin
            logic [3:0] nb;
            nb = w[4*n +: 4];
            if (mst[n] == 0) mst[n] = (nb == 4'hF) ? 1 : 2;
            else if (mst[n] == 1 && nb == 4'h0) begin
               if (mmode) mst[n] = 2;
               else begin mst[n] = 3; mdl[n] = s; end
            end else if (mst[n] == 2 && nb == 4'hF) begin
               if (mmode) begin mst[n] = 3; mdl[n] = s; end
               else mst[n] = 1;
            end
         end
      end
   endtask

   task automatic compare_all();
      logic [NG-1:0]   ed;
      logic [NG*8-1:0] ey;
      for (int n = 0; n < NG; n++) begin
         ed[n] = (mst[n] == 3);
         ey[8*n +: 8] = 8'(mdl[n]);
      end
      check({tag, " done_o"}, 192'(done_o), 192'(ed));
      check({tag, " delay_o"}, 192'(delay_o), 192'(ey));
      check({tag, " R11 all_done_o"}, 192'(all_done_o), 192'(&ed));
   endtask

   task automatic cyc(input bit st, input bit cl, input bit v, input bit rm,
                      input logic [71:0] w, input logic [7:0] s);
      @(negedge clk);
      start_i = st; clear_i = cl; smp_valid_i = v; rise_mode_i = rm;
      smp_word_i = w; step_i = s;
      @(posedge clk);
      #1;
      model_step(st, cl, v, rm, w, s);
      compare_all();
   endtask

   function automatic logic [71:0] fill(input logic [3:0] even_v, input logic [3:0] odd_v);
      logic [71:0] w;
      for (int n = 0; n < NG; n++) w[4*n +: 4] = (n % 2 == 0) ? even_v : odd_v;
      return w;
   endfunction

   function automatic logic [71:0] rnd_word();
      logic [71:0] w;
      for (int n = 0; n < NG; n++) begin
         int r;
         r = int'($urandom % 5);
         if (r < 2) w[4*n +: 4] = 4'h0;
         else if (r < 4) w[4*n +: 4] = 4'hF;
         else w[4*n +: 4] = 4'(1 + $urandom % 14);
      end
      return w;
   endfunction

   initial begin
      #(8 * 150000);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      model_reset();
      #1;
      // R1: reset state
      check("R1 reset done_o", 192'(done_o), 192'(0));
      check("R1 reset delay_o", 192'(delay_o), 192'(0));
      check("R1 reset all_done_o", 192'(all_done_o), 192'(0));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Falling mode: even groups start high, odd groups start low
      tag = "R3 R4 R5 R8 R10";
      cyc(1, 0, 0, 0, '0, 0);
      cyc(0, 0, 1, 0, fill(4'hF, 4'h0), 1);
      check("R3 no done on baseline", 192'(done_o), 192'(0));
      cyc(0, 0, 1, 0, fill(4'h5, 4'h5), 2);           // R8 mixed ignored
      check("R8 mixed no change", 192'(done_o), 192'(0));
      cyc(0, 0, 1, 0, fill(4'h0, 4'h0), 3);           // R4 even groups finish
      check("R4 group0 done", 192'(done_o[0]), 192'(1));
      check("R4 group0 delay", 192'(delay_o[7:0]), 192'(3));
      check("R4 group1 still open", 192'(done_o[1]), 192'(0));
      cyc(0, 0, 1, 0, fill(4'hF, 4'hF), 4);           // R5 low->high not an edge
      check("R5 group1 not done on rise", 192'(done_o[1]), 192'(0));
      cyc(0, 0, 0, 0, fill(4'h0, 4'h0), 5);           // R10 strobe low
      check("R10 no strobe", 192'(done_o[1]), 192'(0));
      cyc(0, 0, 1, 0, fill(4'h0, 4'h0), 6);
      check("R2 group1 delay field", 192'(delay_o[15:8]), 192'(6));
      check("R11 all done", 192'(all_done_o), 192'(1));
      tag = "R9";
      cyc(0, 0, 1, 0, fill(4'hF, 4'hF), 7);
      cyc(0, 0, 1, 0, fill(4'h0, 4'h0), 8);
      check("R9 sticky delay", 192'(delay_o[7:0]), 192'(3));

      // R2: only the top group sees an edge
      tag = "R2";
      cyc(0, 1, 0, 0, '0, 0);
      cyc(0, 0, 1, 1, {72{1'b1}}, 9);                 // R12: mode input ignored without start
      cyc(0, 0, 1, 0, {4'h0, {68{1'b1}}}, 10);
      check("R2 only group17", 192'(done_o), 192'(18'h20000));
      check("R2 group17 delay", 192'(delay_o[143:136]), 192'(10));

      // Rising mode; start with a valid sample drops that sample
      tag = "R6 R7 R10 R12";
      cyc(1, 0, 1, 1, {72{1'b1}}, 20);
      check("R10 sample dropped on start", 192'(done_o), 192'(0));
      cyc(0, 0, 1, 0, {{36{1'b1}}, {9{4'h3}}}, 21);   // low half mixed -> low baseline
      cyc(0, 0, 1, 0, {{36{1'b0}}, {9{4'h7}}}, 22);   // R7 high half -> low
      check("R7 no done on fall", 192'(done_o), 192'(0));
      cyc(0, 0, 1, 0, {72{1'b1}}, 23);                // R6
      check("R6 group0 done", 192'(done_o[0]), 192'(1));
      check("R7 group17 done after fall", 192'(done_o[17]), 192'(1));
      check("R6 group17 delay", 192'(delay_o[143:136]), 192'(23));

      // R12: clear keeps rising mode
      tag = "R12";
      cyc(0, 1, 0, 0, '0, 0);
      cyc(0, 0, 1, 0, {72{1'b0}}, 30);
      cyc(0, 0, 1, 0, {72{1'b1}}, 31);
      check("R12 mode kept over clear", 192'(all_done_o), 192'(1));

      // Random sweeps
      tag = "R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random";
      for (int k = 0; k < 3000; k++) begin
         int r;
         r = int'($urandom % 100);
         cyc(r < 2, r >= 2 && r < 3, ($urandom % 4) != 0, 1'($urandom),
             rnd_word(), 8'($urandom));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule